// File: doc/BRIEF.md
# Page Write Latch with Self-Timed Commit

This block sits behind the serial protocol engine of a byte-wide nonvolatile memory. It collects the data bytes of one write transaction in a page-sized holding latch. When the transaction's STOP arrives, it runs a write cycle of fixed length that copies the collected bytes into the storage array through a one-byte write port. While that cycle runs, the block holds `busy` high. The protocol engine uses `busy` to withhold acknowledges, so a host can poll for completion.

The first byte accepted in a transaction loads an internal pointer from `wr_addr`. The upper address bits of that byte fix the page for the whole transaction. Each later byte goes to the next slot of the same page, and only the slot bits count up. Bytes beyond one page therefore wrap to the start of the page and replace what was held there.

The array is touched only by a completed, unprotected transaction. Only the slots actually filled in that transaction are written. The write-protect level is sampled at STOP, and a protected transaction is thrown away. The cycle length is a parameter counted in clock cycles, so a short value can stand in for the multi-millisecond interval.

Top module: `page_commit`

## Requirements
- R1: The first byte accepted after the block is idle (no bytes held) lands at the slot and page given by its own `wr_addr`. For every later byte of the same transaction, `wr_addr` is ignored.
- R2: After each accepted byte, only the low log2(PAGE_BYTES) bits of the pointer (bits 4:0 by default) advance by one. A byte written past the last slot of the page goes to slot 0 of the same page and replaces the byte that slot held.
- R3: The array port writes nothing before STOP. `busy` rises on the first clock after a STOP that starts a cycle and stays high for exactly WRITE_CYCLES cycles.
- R4: During the cycle, each slot filled in the transaction is written exactly once, in ascending slot order, at address {page, slot}, with the last byte received for that slot. Unfilled slots are not written.
- R5: A STOP when no byte is held and none is offered in the same cycle starts no cycle. `busy` stays low and nothing is written.
- R6: A STOP with `wp_in` high discards the held bytes. No cycle starts and nothing is written, and the next transaction starts empty.
- R7: While `busy` is high, byte strobes and STOP pulses are ignored. They neither extend the cycle nor enter the latch.
- R8: A byte strobe in the same cycle as STOP is taken into the page and committed with it. It alone is enough to start a cycle.
- R9: During reset `busy` and `arr_we` are low.
- R10: `arr_we` is high only while `busy` is high (requires WRITE_CYCLES >= PAGE_BYTES + 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Byte strobe from the protocol engine |
| wr_addr | input | ADDR_W | Byte address; used on the first byte of a transaction only |
| wr_data | input | 8 | Byte to hold |
| stop_pulse | input | 1 | One-cycle pulse marking the end of the transaction |
| wp_in | input | 1 | Write protect, sampled with STOP; high discards the transaction |
| busy | output | 1 | Write cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | 8 | Array write data |

## Verification
Two events can meet in one cycle: a byte strobe and the STOP that ends its transaction. The bench puts both on the same clock, both with and without earlier bytes. It then checks that the extra byte starts the cycle and is committed at the right slot. A second overlap also gets its own test: a strobe and a STOP arriving together while a cycle is running. The bench judges it by the length of `busy` and by a STOP sent afterwards with no bytes, which must not raise `busy`.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/page_commit_ptr.sv
// Slot pointer, page register and per-slot fill flags.
module page_commit_ptr #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int OFF_W      = 5,
  parameter int PG_W       = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic                  clear,
  input  logic [ADDR_W-1:0]     addr_in,
  output logic [PG_W-1:0]       page_q,
  output logic [OFF_W-1:0]      slot,
  output logic                  have_q,
  output logic [PAGE_BYTES-1:0] valid_q
);
  logic [OFF_W-1:0] off_q;

  // first byte of a transaction takes its slot from the address
  assign slot = have_q ? off_q : addr_in[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      off_q   <= '0;
      have_q  <= 1'b0;
      valid_q <= '0;
    end else if (clear) begin
      have_q  <= 1'b0;
      valid_q <= '0;
    end else if (take) begin
      if (!have_q) page_q <= addr_in[ADDR_W-1:OFF_W];
      off_q         <= slot + OFF_W'(1);
      have_q        <= 1'b1;
      valid_q[slot] <= 1'b1;
    end
  end
endmodule

// File: rtl/page_commit_latch.sv
// Page holding store: one write port, one registered read port.
module page_commit_latch #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_commit_seq.sv
// Write-cycle timer and slot scanner.
module page_commit_seq #(
  parameter int PAGE_BYTES   = 32,
  parameter int OFF_W        = 5,
  parameter int WRITE_CYCLES = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy_q,
  output logic             done,
  output logic [OFF_W-1:0] scan_idx,
  output logic             scan_act
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  assign done = busy_q && (cnt_q == CNT_W'(WRITE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      scan_idx <= '0;
      scan_act <= 1'b0;
    end else if (start) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      scan_idx <= '0;
      scan_act <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (done) busy_q <= 1'b0;
      if (scan_act) begin
        scan_idx <= scan_idx + OFF_W'(1);
        if (scan_idx == OFF_W'(PAGE_BYTES - 1)) scan_act <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/page_commit.sv
module page_commit #(
  parameter int ADDR_W       = 12,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              stop_pulse,
  input  logic              wp_in,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data
);
  import page_commit_pkg::*;
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  logic                  take, start, drop, done;
  logic [PG_W-1:0]       page_q;
  logic [OFF_W-1:0]      slot, scan_idx, rd_off;
  logic                  have_q, scan_act, rd_v;
  logic [PAGE_BYTES-1:0] valid_q;
  byte_t                 rd_data;

  assign take  = wr_valid && !busy;
  assign start = stop_pulse && !busy && !wp_in && (have_q || wr_valid);
  assign drop  = stop_pulse && !busy && !start;

  page_commit_ptr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .PG_W(PG_W)) u_ptr (
    .clk(clk), .rst(rst), .take(take), .clear(drop || done), .addr_in(wr_addr),
    .page_q(page_q), .slot(slot), .have_q(have_q), .valid_q(valid_q)
  );

  page_commit_latch #(.DATA_W(BYTE_W), .DEPTH(PAGE_BYTES), .IDX_W(OFF_W)) u_latch (
    .clk(clk), .we(take), .waddr(slot), .wdata(wr_data),
    .raddr(scan_idx), .rdata(rd_data)
  );

  page_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy_q(busy), .done(done),
    .scan_idx(scan_idx), .scan_act(scan_act)
  );

  // read stage aligned with the latch read, then registered write port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v     <= 1'b0;
      rd_off   <= '0;
      arr_we   <= 1'b0;
      arr_addr <= '0;
      arr_data <= '0;
    end else begin
      rd_v     <= scan_act && valid_q[scan_idx];
      rd_off   <= scan_idx;
      arr_we   <= rd_v;
      arr_addr <= {page_q, rd_off};
      arr_data <= rd_data;
    end
  end
endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              stop_pulse,
  input logic              wp_in,
  input logic              have,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  // R10
  p_we_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
  // R3
  p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_pulse));
  // R6
  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (stop_pulse && wp_in && !busy) |=> !busy);
  // R5
  p_empty_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (stop_pulse && !busy && !wr_valid && !have) |=> !busy);
  // R4
  p_one_page_r4: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |->
      (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])));
  // R4
  p_slot_order_r4: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |-> (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])));
  // R9
  p_reset_quiet_r9: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !arr_we));
endmodule

bind page_commit page_commit_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .stop_pulse(stop_pulse), .wp_in(wp_in),
  .have(have_q), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/tb_page_commit.sv
module tb_page_commit;
  localparam int AW = 12;
  localparam int PB = 32;
  localparam int WC = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          stop_pulse = 1'b0;
  logic          wp_in = 1'b0;
  logic          busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_data;

  page_commit #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .stop_pulse(stop_pulse), .wp_in(wp_in), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit summary_done = 0;

  // reference model of one transaction
  bit        m_have;
  logic [6:0] m_page;
  logic [4:0] m_off;
  logic [7:0] m_data [PB];
  bit        m_v    [PB];
  bit        seen   [PB];
  bit        expect_commit = 0;
  int        n_got = 0;

  function automatic int pop_valid();
    int n = 0;
    for (int i = 0; i < PB; i++) if (m_v[i]) n++;
    return n;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [6:0] pg, input logic [4:0] sl);
    return {pg, sl};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_have = 0;
    for (int i = 0; i < PB; i++) begin m_v[i] = 0; seen[i] = 0; end
    n_got = 0;
  endtask

  task automatic model_take(input logic [AW-1:0] a, input logic [7:0] d);
    logic [4:0] s;
    if (!m_have) begin m_page = a[AW-1:5]; s = a[4:0]; end
    else s = m_off;
    m_data[s] = d;
    m_v[s] = 1;
    m_off = s + 5'd1;
    m_have = 1;
  endtask

  // array port monitor
  always @(negedge clk) begin
    if (!rst && arr_we) begin
      if (!expect_commit) chk(0, "R3 write without commit", arr_addr, 0);
      else begin
        chk(arr_addr[AW-1:5] == m_page, "R1 page", arr_addr, exp_addr(m_page, arr_addr[4:0]));
        chk(m_v[arr_addr[4:0]] && !seen[arr_addr[4:0]], "R4 slot filled once",
            arr_addr[4:0], m_v[arr_addr[4:0]]);
        chk(arr_data == m_data[arr_addr[4:0]], "R2 data", arr_data, m_data[arr_addr[4:0]]);
        seen[arr_addr[4:0]] = 1;
        n_got++;
      end
    end
  end

  // called at the negedge after the STOP edge
  task automatic finish_stop(input bit wpv, input bit inject, input string req);
    bit go;
    int cnt;
    go = m_have && !wpv;
    chk(busy == go, req, busy, go);
    if (go) begin
      expect_commit = 1;
      cnt = 0;
      while (busy && cnt < 4 * WC) begin
        if (inject && cnt == 10) begin
          wr_valid = 1; wr_addr = AW'($urandom); wr_data = 8'hEE; stop_pulse = 1;
        end else begin
          wr_valid = 0; stop_pulse = 0;
        end
        cnt++;
        @(negedge clk);
      end
      wr_valid = 0; stop_pulse = 0;
      chk(cnt == WC, inject ? "R7 busy length" : "R3 busy length", cnt, WC);
      chk(n_got == pop_valid(), "R4 write count", n_got, pop_valid());
      expect_commit = 0;
    end else begin
      repeat (3) @(negedge clk);
      chk(!busy, req, busy, 0);
    end
    model_clear();
  endtask

  task automatic put_byte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    model_take(a, d);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic send_stop(input bit wpv, input bit inject, input string req);
    @(negedge clk);
    stop_pulse = 1; wp_in = wpv;
    @(negedge clk);
    stop_pulse = 0; wp_in = 0;
    finish_stop(wpv, inject, req);
  endtask

  // last byte of n offered together with STOP (R8)
  task automatic txn(input logic [AW-1:0] a, input int n, input bit wpv,
                     input bit together, input bit inject, input string req);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] aa;
      aa = (i == 0) ? a : AW'($urandom);
      if (together && i == n - 1) begin
        @(negedge clk);
        wr_valid = 1; wr_addr = aa; wr_data = 8'($urandom);
        stop_pulse = 1; wp_in = wpv;
        model_take(aa, wr_data);
        @(negedge clk);
        wr_valid = 0; stop_pulse = 0; wp_in = 0;
        finish_stop(wpv, inject, req);
      end else begin
        put_byte(aa, 8'($urandom));
        if ($urandom_range(0, 3) == 0) @(negedge clk);
      end
    end
    if (!together) send_stop(wpv, inject, req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !summary_done) begin
      summary_done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_clear();
    repeat (3) @(negedge clk);
    chk(!busy && !arr_we, "R9 reset", {busy, arr_we}, 0);
    rst = 0;
    @(negedge clk);
    // directed
    txn(12'h123, 1, 0, 0, 0, "R3 single byte");
    txn(12'h1F8, 40, 0, 0, 0, "R2 wrap");
    txn(12'hA40, 32, 0, 0, 0, "R1 full page");
    send_stop(0, 0, "R5 empty stop");
    txn(12'h300, 5, 1, 0, 0, "R6 protected");
    send_stop(0, 0, "R6 latch emptied");
    txn(12'h555, 1, 0, 1, 0, "R8 lone byte with stop");
    txn(12'h7E0, 6, 0, 1, 0, "R8 byte with stop");
    txn(12'h0C3, 3, 0, 0, 1, "R7 inject");
    send_stop(0, 0, "R7 stray byte ignored");
    txn(12'h800, 4, 1, 1, 0, "R6 protected with byte");
    // random
    for (int t = 0; t < 40; t++) begin
      int n;
      bit wpv, tog;
      n   = $urandom_range(0, 70);
      wpv = ($urandom_range(0, 4) == 0);
      tog = (n > 0) && ($urandom_range(0, 3) == 0);
      txn(AW'($urandom), n, wpv, tog, ($urandom_range(0, 5) == 0),
          n == 0 ? "R5 random" : (wpv ? "R6 random" : "R3 random"));
    end
    if (!summary_done) begin
      summary_done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule